// File: doc/BRIEF.md
# Receive Descriptor Ring Writer

This block is the receive-side descriptor manager of an Ethernet DMA engine. It owns a small on-chip store of two-word receive descriptors that the host fills and reads through a simple word port. Each descriptor has a buffer word and a status word. The buffer word holds an ownership bit, a ring-end bit and the buffer address. The status word records what landed in the buffer.

When the receive path announces a buffer-sized piece of a frame, the block checks who owns the current descriptor. If the hardware owns it, the block writes the record into the status word. It then sets the ownership bit as its final write and moves on through the ring. The end of the ring is marked by a bit in memory, not by a count. If the host still owns the descriptor, or a second announcement arrives while one is being handled, the piece is dropped and counted.

The host chooses where the ring starts by writing a ring-start slot. That write also returns the walk to the first descriptor of the ring. The payload bytes and the system bus are handled elsewhere.

Top module: `rxr_ring_writer`

## Requirements
- R1: After reset, `rx_slot` and `drop_count` are 0, `rx_done` and `rx_drop` are low, and every descriptor word reads as 0.
- R2: `host_addr` selects a slot in its upper bits, and bit 0 selects the word within the slot: 0 for the buffer word, 1 for the status word. A host write lands at the clock edge. `host_rdata` shows the addressed word one cycle after the address is presented.
- R3: A piece stored into a descriptor leaves these fields in the status word: bit 15 is the end marker, bit 14 is the start marker, bits 13:0 are the length, and bits 31:16 are 0. In the buffer word, bit 0 becomes 1 and bits 31:1 are kept. A single-buffer frame has both markers set.
- R4: With no host contention, `rx_done` pulses for one cycle, three cycles after the cycle in which `frame_valid` was sampled. The buffer word, which carries the ownership bit, is written only after the status word.
- R5: If bit 0 of the current buffer word is already 1, the piece is dropped. `rx_drop` pulses one cycle after the sampling cycle, and `drop_count` rises by 1. The descriptor and `rx_slot` stay unchanged.
- R6: After a store, `rx_slot` moves to the ring-start slot if bit 1 of that buffer word was 1. Otherwise it moves to the next slot, rolling over from the last slot to slot 0.
- R7: A write on `qbase_we` sets the ring-start slot, and `rx_slot` equals the written value on the next cycle. A store already in flight finishes at its own slot without moving `rx_slot` again.
- R8: A `frame_valid` sampled while a piece is still being handled is dropped and counted, and `rx_drop` pulses on the next cycle.
- R9: `drop_count` saturates at its all-ones value.
- R10: A host write has priority over the block's own descriptor write in the same cycle. The block retries its write on the next cycle, so both writes land and `rx_done` comes one cycle later per stalled write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_valid | input | 1 | One-cycle announcement of a received buffer |
| frame_len | input | 14 | Byte length for that buffer |
| frame_sof | input | 1 | Buffer starts a frame |
| frame_eof | input | 1 | Buffer ends a frame |
| host_we | input | 1 | Host descriptor-word write enable |
| host_addr | input | SW+1 | Host word address: {slot, word select} |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Registered host read data |
| qbase_we | input | 1 | Write enable for the ring-start slot |
| qbase_wdata | input | SW | Ring-start slot value |
| rx_slot | output | SW | Slot the next buffer will go to |
| rx_done | output | 1 | Pulse: a descriptor was handed to the host |
| rx_drop | output | 1 | Pulse: a buffer was dropped |
| drop_count | output | DROP_W | Saturating count of dropped buffers |

SW is log2(SLOTS).

## Verification
The checker assumes that reset is high from time zero until after the first edge. It also assumes that an ownership drop and a busy-time announcement never fall in the same cycle, because the counter adds at most one per cycle. The bench never announces a buffer while it is already waiting on a descriptor that the host owns. It places host writes and ring-start writes only at chosen cycles, and the stall and rebase cases use exactly those cycles. Each piece is announced with a one-cycle strobe. The only exception is the busy case, where the strobe is held on purpose for a second cycle.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

    localparam int WORD_W   = 32;
    localparam int LEN_W    = 14;
    localparam int OWN_POS  = 0;   // hardware-filled flag in buffer word
    localparam int RING_END = 1;   // last descriptor of the ring

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_CHECK,
        ST_WSTAT,
        ST_WADDR
    } rxr_state_e;

    typedef enum logic {
        SEL_BUF  = 1'b0,
        SEL_STAT = 1'b1
    } rxr_word_e;

    // Order of fields equals the bit layout of the low status half.
    typedef struct packed {
        logic             eof;
        logic             sof;
        logic [LEN_W-1:0] len;
    } rxr_rec_t;

    function automatic logic [WORD_W-1:0] status_word(input rxr_rec_t r);
        return {{(WORD_W - $bits(rxr_rec_t)){1'b0}}, r};
    endfunction

    function automatic logic [WORD_W-1:0] claim_word(input logic [WORD_W-1:0] w);
        logic [WORD_W-1:0] t;
        t = w;
        t[OWN_POS] = 1'b1;
        return t;
    endfunction

endpackage

// File: rtl/rxr_desc_mem.sv
module rxr_desc_mem
    import rxr_pkg::*;
#(
    parameter int SLOTS = 32,
    parameter int SW    = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              host_we,
    input  logic [SW:0]       host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    input  logic [SW-1:0]     eng_rd_slot,
    output logic [WORD_W-1:0] eng_rd_buf,
    input  logic              eng_we,
    input  rxr_word_e         eng_sel,
    input  logic [SW-1:0]     eng_slot,
    input  logic [WORD_W-1:0] eng_wdata,
    output logic              eng_grant
);

    logic [SW-1:0]     host_slot;
    rxr_word_e         host_sel;
    logic [WORD_W-1:0] buf_rd  [SLOTS];
    logic [WORD_W-1:0] stat_rd [SLOTS];

    assign host_slot = host_addr[SW:1];
    assign host_sel  = rxr_word_e'(host_addr[0]);
    assign eng_grant = !host_we;

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        logic [WORD_W-1:0] buf_q;
        logic [WORD_W-1:0] stat_q;
        logic              host_hit;
        logic              eng_hit;

        assign host_hit = host_we && (host_slot == SW'(g));
        assign eng_hit  = eng_we && eng_grant && (eng_slot == SW'(g));

        always_ff @(posedge clk) begin
            if (rst) begin
                buf_q  <= '0;
                stat_q <= '0;
            end else if (host_hit) begin
                if (host_sel == SEL_STAT) stat_q <= host_wdata;
                else                      buf_q  <= host_wdata;
            end else if (eng_hit) begin
                if (eng_sel == SEL_STAT) stat_q <= eng_wdata;
                else                     buf_q  <= eng_wdata;
            end
        end

        assign buf_rd[g]  = buf_q;
        assign stat_rd[g] = stat_q;
    end

    assign eng_rd_buf = buf_rd[eng_rd_slot];

    always_ff @(posedge clk) begin
        if (rst) host_rdata <= '0;
        else     host_rdata <= (host_sel == SEL_STAT) ? stat_rd[host_slot] : buf_rd[host_slot];
    end

endmodule

// File: rtl/rxr_drop_ctr.sv
module rxr_drop_ctr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         inc,
    output logic [W-1:0] count
);

    localparam logic [W-1:0] TOP = '1;

    always_ff @(posedge clk) begin
        if (rst)                      count <= '0;
        else if (inc && count != TOP) count <= count + W'(1);
    end

endmodule

// File: rtl/rxr_ring_ctrl.sv
module rxr_ring_ctrl
    import rxr_pkg::*;
#(
    parameter int SLOTS = 32,
    parameter int SW    = 5
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_valid,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic              frame_sof,
    input  logic              frame_eof,
    input  logic              qbase_we,
    input  logic [SW-1:0]     qbase_wdata,
    input  logic [WORD_W-1:0] eng_rd_buf,
    input  logic              eng_grant,
    output logic [SW-1:0]     eng_rd_slot,
    output logic              eng_we,
    output rxr_word_e         eng_sel,
    output logic [SW-1:0]     eng_slot,
    output logic [WORD_W-1:0] eng_wdata,
    output logic [SW-1:0]     rx_slot,
    output logic              rx_done,
    output logic              rx_drop,
    output logic              drop_now,
    output rxr_state_e        state
);

    localparam logic [SW-1:0] LAST = SW'(SLOTS - 1);

    logic [SW-1:0] cur_slot, base_slot, work_slot, next_slot;
    rxr_rec_t      rec;
    logic          rebased;
    logic          busy_strobe, owned_hit, finish;

    assign eng_rd_slot = (state == ST_WADDR) ? work_slot : cur_slot;
    assign busy_strobe = frame_valid && (state != ST_IDLE);
    assign owned_hit   = (state == ST_CHECK) && eng_rd_buf[OWN_POS];
    assign drop_now    = busy_strobe || owned_hit;
    assign finish      = (state == ST_WADDR) && eng_grant;

    assign eng_we    = (state == ST_WSTAT) || (state == ST_WADDR);
    assign eng_sel   = (state == ST_WADDR) ? SEL_BUF : SEL_STAT;
    assign eng_slot  = work_slot;
    assign eng_wdata = (state == ST_WADDR) ? claim_word(eng_rd_buf) : status_word(rec);

    always_comb begin
        if (eng_rd_buf[RING_END])   next_slot = base_slot;
        else if (work_slot == LAST) next_slot = '0;
        else                        next_slot = work_slot + SW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            cur_slot  <= '0;
            base_slot <= '0;
            work_slot <= '0;
            rec       <= '0;
            rebased   <= 1'b0;
            rx_done   <= 1'b0;
            rx_drop   <= 1'b0;
        end else begin
            rx_done <= finish;
            rx_drop <= drop_now;
            rebased <= (state == ST_IDLE) ? 1'b0 : (rebased || qbase_we);
            if (qbase_we) base_slot <= qbase_wdata;

            if (qbase_we)                cur_slot <= qbase_wdata;
            else if (finish && !rebased) cur_slot <= next_slot;

            unique case (state)
                ST_IDLE: if (frame_valid) begin
                    rec.len <= frame_len;
                    rec.sof <= frame_sof;
                    rec.eof <= frame_eof;
                    state   <= ST_CHECK;
                end
                ST_CHECK: begin
                    work_slot <= cur_slot;
                    state     <= owned_hit ? ST_IDLE : ST_WSTAT;
                end
                ST_WSTAT: if (eng_grant) state <= ST_WADDR;
                ST_WADDR: if (eng_grant) state <= ST_IDLE;
                default:  state <= ST_IDLE;
            endcase
        end
    end

    assign rx_slot = cur_slot;

endmodule

// File: rtl/rxr_ring_writer.sv
module rxr_ring_writer
    import rxr_pkg::*;
#(
    parameter int SLOTS  = 32,
    parameter int DROP_W = 16,
    localparam int SW    = $clog2(SLOTS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_valid,
    input  logic [LEN_W-1:0]  frame_len,
    input  logic              frame_sof,
    input  logic              frame_eof,
    input  logic              host_we,
    input  logic [SW:0]       host_addr,
    input  logic [WORD_W-1:0] host_wdata,
    output logic [WORD_W-1:0] host_rdata,
    input  logic              qbase_we,
    input  logic [SW-1:0]     qbase_wdata,
    output logic [SW-1:0]     rx_slot,
    output logic              rx_done,
    output logic              rx_drop,
    output logic [DROP_W-1:0] drop_count
);

    logic [SW-1:0]     eng_rd_slot, eng_slot;
    logic [WORD_W-1:0] eng_rd_buf, eng_wdata;
    logic              eng_we, eng_grant, drop_now;
    rxr_word_e         eng_sel;
    rxr_state_e        ctrl_state;

    rxr_desc_mem #(.SLOTS(SLOTS), .SW(SW)) u_mem (
        .clk        (clk),
        .rst        (rst),
        .host_we    (host_we),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .eng_rd_slot(eng_rd_slot),
        .eng_rd_buf (eng_rd_buf),
        .eng_we     (eng_we),
        .eng_sel    (eng_sel),
        .eng_slot   (eng_slot),
        .eng_wdata  (eng_wdata),
        .eng_grant  (eng_grant)
    );

    rxr_ring_ctrl #(.SLOTS(SLOTS), .SW(SW)) u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .frame_valid(frame_valid),
        .frame_len  (frame_len),
        .frame_sof  (frame_sof),
        .frame_eof  (frame_eof),
        .qbase_we   (qbase_we),
        .qbase_wdata(qbase_wdata),
        .eng_rd_buf (eng_rd_buf),
        .eng_grant  (eng_grant),
        .eng_rd_slot(eng_rd_slot),
        .eng_we     (eng_we),
        .eng_sel    (eng_sel),
        .eng_slot   (eng_slot),
        .eng_wdata  (eng_wdata),
        .rx_slot    (rx_slot),
        .rx_done    (rx_done),
        .rx_drop    (rx_drop),
        .drop_now   (drop_now),
        .state      (ctrl_state)
    );

    rxr_drop_ctr #(.W(DROP_W)) u_drops (
        .clk  (clk),
        .rst  (rst),
        .inc  (drop_now),
        .count(drop_count)
    );

endmodule

// File: rtl/rxr_ring_checker.sv
module rxr_ring_checker
    import rxr_pkg::*;
#(
    parameter int SW     = 5,
    parameter int DROP_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              frame_valid,
    input logic              qbase_we,
    input logic [SW-1:0]     qbase_wdata,
    input logic [SW-1:0]     rx_slot,
    input logic              rx_done,
    input logic              rx_drop,
    input logic [DROP_W-1:0] drop_count,
    input rxr_state_e        ctrl_state
);

    p_reset_clear_r1: assert property (@(posedge clk) $fell(rst) |-> (drop_count == '0 && rx_slot == '0));

    p_claim_after_status_r4: assert property (@(posedge clk) disable iff (rst)
        (ctrl_state == ST_WADDR) |-> ($past(ctrl_state) == ST_WSTAT || $past(ctrl_state) == ST_WADDR));

    p_done_from_claim_r4: assert property (@(posedge clk) disable iff (rst)
        rx_done |-> ($past(ctrl_state) == ST_WADDR));

    p_drop_step_r5: assert property (@(posedge clk) disable iff (rst)
        (drop_count != $past(drop_count)) |-> (drop_count == $past(drop_count) + DROP_W'(1)));

    p_drop_pulse_r5: assert property (@(posedge clk) disable iff (rst)
        (drop_count != $past(drop_count)) |-> rx_drop);

    p_slot_moves_r6: assert property (@(posedge clk) disable iff (rst)
        (rx_slot != $past(rx_slot)) |-> (rx_done || $past(qbase_we)));

    p_rebase_r7: assert property (@(posedge clk) disable iff (rst)
        qbase_we |=> (rx_slot == $past(qbase_wdata)));

    p_busy_drop_r8: assert property (@(posedge clk) disable iff (rst)
        (frame_valid && ctrl_state != ST_IDLE) |=> rx_drop);

    p_saturate_r9: assert property (@(posedge clk) disable iff (rst)
        (drop_count == '1) |=> (drop_count == '1));

endmodule

bind rxr_ring_writer rxr_ring_checker #(.SW(SW), .DROP_W(DROP_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .frame_valid(frame_valid),
    .qbase_we   (qbase_we),
    .qbase_wdata(qbase_wdata),
    .rx_slot    (rx_slot),
    .rx_done    (rx_done),
    .rx_drop    (rx_drop),
    .drop_count (drop_count),
    .ctrl_state (ctrl_state)
);

// File: tb/tb_rxr_ring_writer.sv
module tb_rxr_ring_writer;

    localparam int SLOTS  = 32;
    localparam int DROP_W = 4;
    localparam int SW     = $clog2(SLOTS);

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              frame_valid = 1'b0;
    logic [13:0]       frame_len = '0;
    logic              frame_sof = 1'b0;
    logic              frame_eof = 1'b0;
    logic              host_we = 1'b0;
    logic [SW:0]       host_addr = '0;
    logic [31:0]       host_wdata = '0;
    logic [31:0]       host_rdata;
    logic              qbase_we = 1'b0;
    logic [SW-1:0]     qbase_wdata = '0;
    logic [SW-1:0]     rx_slot;
    logic              rx_done, rx_drop;
    logic [DROP_W-1:0] drop_count;

    int checks = 0;
    int fails  = 0;
    logic [31:0] rd;
    int          lat;
    logic        got_done, got_drop;

    always #4 clk = ~clk;

    rxr_ring_writer #(.SLOTS(SLOTS), .DROP_W(DROP_W)) dut (
        .clk(clk), .rst(rst),
        .frame_valid(frame_valid), .frame_len(frame_len),
        .frame_sof(frame_sof), .frame_eof(frame_eof),
        .host_we(host_we), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata),
        .qbase_we(qbase_we), .qbase_wdata(qbase_wdata),
        .rx_slot(rx_slot), .rx_done(rx_done), .rx_drop(rx_drop),
        .drop_count(drop_count)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hwrite(input int slot, input int sel, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = {SW'(slot), sel[0]}; host_wdata = d;
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic hread(input int slot, input int sel, output logic [31:0] d);
        @(negedge clk);
        host_addr = {SW'(slot), sel[0]};
        @(negedge clk);
        d = host_rdata;
    endtask

    task automatic rebase(input int slot);
        @(negedge clk);
        qbase_we = 1'b1; qbase_wdata = SW'(slot);
        @(negedge clk);
        qbase_we = 1'b0;
    endtask

    // Strobe one buffer; lat counts negedges after strobe until an outcome.
    task automatic send(input int len, input logic sof, input logic eof);
        @(negedge clk);
        frame_valid = 1'b1; frame_len = 14'(len); frame_sof = sof; frame_eof = eof;
        @(negedge clk);
        frame_valid = 1'b0;
        got_done = 1'b0; got_drop = 1'b0; lat = 0;
        while (lat < 10 && !got_done && !got_drop) begin
            @(negedge clk);
            lat++;
            got_done = rx_done;
            got_drop = rx_drop;
        end
    endtask

    task automatic t_reset;
        chk("R1 slot", 32'(rx_slot), 0);
        chk("R1 drops", 32'(drop_count), 0);
        chk("R1 pulses", {30'd0, rx_done, rx_drop}, 0);
        hread(7, 1, rd);
        chk("R1 word", rd, 0);
    endtask

    task automatic t_host_port;
        hwrite(5, 0, 32'h1000_0000);
        hwrite(5, 1, 32'hF000_0000);
        hread(5, 0, rd);
        chk("R2 buffer word", rd, 32'h1000_0000);
        hread(5, 1, rd);
        chk("R2 status word", rd, 32'hF000_0000);
    endtask

    task automatic t_single;
        hwrite(0, 0, 32'h0000_2000);
        hwrite(0, 1, 32'hF000_0000);
        send(100, 1'b1, 1'b1);
        chk("R4 done latency", 32'(lat), 3);
        chk("R4 done seen", 32'(got_done), 1);
        hread(0, 1, rd);
        chk("R3 single status", rd, 32'h0000_C064);
        hread(0, 0, rd);
        chk("R3 claim bit", rd, 32'h0000_2001);
        chk("R6 step", 32'(rx_slot), 1);
    endtask

    task automatic t_multi;
        send(1536, 1'b1, 1'b0);
        send(32, 1'b0, 1'b1);
        hread(1, 1, rd);
        chk("R3 first piece", rd, 32'h0000_4600);
        hread(2, 1, rd);
        chk("R3 last piece", rd, 32'h0000_8020);
        hread(2, 0, rd);
        chk("R3 last claim", rd, 32'h0000_0001);
        chk("R6 slot after two", 32'(rx_slot), 3);
    endtask

    task automatic t_owned_drop;
        hwrite(3, 0, 32'h0000_3001);
        send(64, 1'b1, 1'b1);
        chk("R5 drop pulse", {31'd0, got_drop}, 1);
        chk("R5 drop latency", 32'(lat), 1);
        chk("R5 counter", 32'(drop_count), 1);
        chk("R5 slot held", 32'(rx_slot), 3);
        hread(3, 1, rd);
        chk("R5 status untouched", rd, 0);
        hwrite(3, 0, 32'h0000_3000);
        send(64, 1'b1, 1'b1);
        chk("R5 reclaimed done", 32'(got_done), 1);
        chk("R5 slot after reclaim", 32'(rx_slot), 4);
    endtask

    task automatic t_wrap_rebase;
        rebase(10);
        chk("R7 rebase slot", 32'(rx_slot), 10);
        hwrite(11, 0, 32'h0000_0002);
        send(10, 1'b1, 1'b1);
        chk("R6 into 11", 32'(rx_slot), 11);
        send(11, 1'b1, 1'b1);
        chk("R6 wrap to start", 32'(rx_slot), 10);
        hread(11, 0, rd);
        chk("R6 wrap bit kept", rd, 32'h0000_0003);
        // rebase while a store is in flight: store finishes, slot stays rebased
        hwrite(31, 0, 32'h0);
        rebase(31);
        @(negedge clk);
        frame_valid = 1'b1; frame_len = 14'd5; frame_sof = 1'b1; frame_eof = 1'b1;
        @(negedge clk);
        frame_valid = 1'b0;
        @(negedge clk);
        qbase_we = 1'b1; qbase_wdata = SW'(20);
        @(negedge clk);
        qbase_we = 1'b0;
        repeat (3) @(negedge clk);
        chk("R7 in-flight rebase slot", 32'(rx_slot), 20);
        hread(31, 1, rd);
        chk("R7 in-flight store", rd, 32'h0000_C005);
    endtask

    task automatic t_busy;
        @(negedge clk);
        frame_valid = 1'b1; frame_len = 14'd7; frame_sof = 1'b1; frame_eof = 1'b1;
        @(negedge clk);
        @(negedge clk);
        frame_valid = 1'b0;
        chk("R8 busy drop pulse", {31'd0, rx_drop}, 1);
        chk("R8 busy drop count", 32'(drop_count), 2);
        repeat (2) @(negedge clk);
        chk("R8 first still stored", {31'd0, rx_done}, 1);
        chk("R8 slot", 32'(rx_slot), 21);
    endtask

    task automatic t_collision;
        @(negedge clk);
        frame_valid = 1'b1; frame_len = 14'd9; frame_sof = 1'b1; frame_eof = 1'b1;
        @(negedge clk);
        frame_valid = 1'b0;
        @(negedge clk);
        host_we = 1'b1; host_addr = {SW'(30), 1'b1}; host_wdata = 32'hABCD_0000;
        @(negedge clk);
        host_we = 1'b0;
        @(negedge clk);
        chk("R10 done not yet", {31'd0, rx_done}, 0);
        @(negedge clk);
        chk("R10 done one late", {31'd0, rx_done}, 1);
        hread(30, 1, rd);
        chk("R10 host write landed", rd, 32'hABCD_0000);
        hread(21, 1, rd);
        chk("R10 engine write landed", rd, 32'h0000_C009);
    endtask

    task automatic t_saturate;
        hwrite(22, 0, 32'h0000_0001);
        for (int i = 0; i < 16; i++) send(1, 1'b1, 1'b1);
        chk("R9 saturated", 32'(drop_count), 15);
        chk("R9 last still pulsed", {31'd0, got_drop}, 1);
        chk("R5 slot held at owned", 32'(rx_slot), 22);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_host_port();
        t_single();
        t_multi();
        t_owned_drop();
        t_wrap_rebase();
        t_busy();
        t_collision();
        t_saturate();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule